// File: doc/BRIEF.md
# Floating-Point Sign Injection and Classification Unit

This combinational unit serves the two floating-point operations that never need rounding: sign injection and classification. Sign injection returns the first operand with only its sign bit replaced. The new sign is taken from the second operand, from the inverse of that sign, or from the exclusive-or of both signs. Classification sorts the first operand into one of ten IEEE 754 categories and returns that category as a one-hot mask, zero-extended to the full result width so it can be written to an integer register.

Operands arrive in 64-bit floating-point register form. A precision flag selects double or single precision. In single precision only the low 32 bits of each operand are used. A single-precision sign-injection result carries all ones in its upper 32 bits, which is the boxed form a 64-bit register file expects. No exception flags are produced, and NaN payloads pass through untouched.

Top module: `fp_signclass_unit`

## Requirements
- R1: With `op_sel` = 2'b00 (copy sign), the result is operand A with its sign bit replaced by the sign of operand B. Every other bit of A, including a NaN payload, is unchanged.
- R2: With `op_sel` = 2'b01 (negated sign), the result is operand A with its sign bit replaced by the inverse of the sign of B.
- R3: With `op_sel` = 2'b10 (xor sign), the result is operand A with its sign bit replaced by the exclusive-or of the signs of A and B.
- R4: When `is_double` is 0, sign injection uses only bits 31:0 of both operands, with bit 31 as the sign. Result bits 63:32 are all ones. The upper operand bits have no effect on the result.
- R5: With `op_sel` = 2'b11 (classify), exactly one of result bits 9:0 is set and result bits 63:10 are zero.
- R6: Classification sets bit 0 for negative infinity, bit 3 for negative zero, bit 4 for positive zero and bit 7 for positive infinity.
- R7: Classification sets bit 1 for a negative normal number, bit 2 for a negative subnormal, bit 5 for a positive subnormal and bit 6 for a positive normal number.
- R8: A NaN (exponent all ones, fraction nonzero) sets bit 9 when the fraction's top bit is 1 and bit 8 when that bit is 0, regardless of its sign.
- R9: Operand B has no effect on a classify result. In single precision, bits 63:32 of A have no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand; supplies the magnitude for injection and the value to classify |
| op_b | input | 64 | Second operand; supplies the sign for injection |
| op_sel | input | 2 | 00 copy sign, 01 negated sign, 10 xor sign, 11 classify |
| is_double | input | 1 | 1 selects double precision, 0 selects single precision in bits 31:0 |
| result | output | 64 | Injected value, or the zero-extended class mask |

## Verification
Whenever the inputs settle, the embedded assertions check three things. A classify result has exactly one mask bit set and a zero upper field. Sign injection never disturbs the non-sign bits of A. A single-precision injection always carries the all-ones upper half. Whether the mask names the correct category, including the sign-blind NaN split and the subnormal/normal boundary, can only be shown by the bench. It does so through directed edge values in both precisions, such as minimum subnormal, maximum normal and payload-bearing NaNs, and through random operands with biased exponents.

// File: rtl/fp_signclass_unit.sv
`timescale 1ns/1ps
module fp_signclass_unit #(
  parameter int DEXP  = 11,
  parameter int DFRAC = 52,
  parameter int SEXP  = 8,
  parameter int SFRAC = 23
) (
  input  logic [1+DEXP+DFRAC-1:0] op_a,
  input  logic [1+DEXP+DFRAC-1:0] op_b,
  input  logic [1:0]              op_sel,
  input  logic                    is_double,
  output logic [1+DEXP+DFRAC-1:0] result
);
  localparam int DW      = 1 + DEXP + DFRAC;
  localparam int SW      = 1 + SEXP + SFRAC;
  localparam int NCLASS  = 10;

  localparam logic [1:0] OP_COPY = 2'b00;
  localparam logic [1:0] OP_NEG  = 2'b01;
  localparam logic [1:0] OP_XOR  = 2'b10;
  localparam logic [1:0] OP_CLS  = 2'b11;

  function automatic logic [NCLASS-1:0] sort_class(
    input logic s, input logic e_max, input logic e_zero,
    input logic f_zero, input logic f_top);
    logic [NCLASS-1:0] m;
    m = '0;
    if (e_max) begin
      if (f_zero)     m[s ? 0 : 7] = 1'b1;
      else if (f_top) m[9] = 1'b1;
      else            m[8] = 1'b1;
    end else if (e_zero) begin
      if (f_zero) m[s ? 3 : 4] = 1'b1;
      else        m[s ? 2 : 5] = 1'b1;
    end else begin
      m[s ? 1 : 6] = 1'b1;
    end
    return m;
  endfunction

  logic              sa, sb, new_sign;
  logic [NCLASS-1:0] d_mask, s_mask, mask;

  assign sa = is_double ? op_a[DW-1] : op_a[SW-1];
  assign sb = is_double ? op_b[DW-1] : op_b[SW-1];

  assign d_mask = sort_class(op_a[DW-1], &op_a[DW-2:DFRAC], ~|op_a[DW-2:DFRAC],
                             ~|op_a[DFRAC-1:0], op_a[DFRAC-1]);
  assign s_mask = sort_class(op_a[SW-1], &op_a[SW-2:SFRAC], ~|op_a[SW-2:SFRAC],
                             ~|op_a[SFRAC-1:0], op_a[SFRAC-1]);
  assign mask   = is_double ? d_mask : s_mask;

  always_comb begin
    case (op_sel)
      OP_COPY: new_sign = sb;
      OP_NEG:  new_sign = ~sb;
      default: new_sign = sa ^ sb;
    endcase
  end

  always_comb begin
    if (op_sel == OP_CLS)
      result = {{(DW-NCLASS){1'b0}}, mask};
    else if (is_double)
      result = {new_sign, op_a[DW-2:0]};
    else
      result = {{(DW-SW){1'b1}}, new_sign, op_a[SW-2:0]};
  end

  always_comb begin
    if (op_sel == OP_CLS) begin
      // R5
      one_class_chk: assert ($countones(result[NCLASS-1:0]) == 1 && result[DW-1:NCLASS] == '0);
    end
    if (op_sel != OP_CLS && is_double) begin
      // R1
      body_kept_chk: assert (result[DW-2:0] == op_a[DW-2:0]);
    end
    if (op_sel != OP_CLS && !is_double) begin
      // R4
      single_box_chk: assert (&result[DW-1:SW] && result[SW-2:0] == op_a[SW-2:0]);
    end
    if (op_sel == OP_NEG) begin
      // R2
      neg_sign_chk: assert ((is_double ? result[DW-1] : result[SW-1]) != (is_double ? op_b[DW-1] : op_b[SW-1]));
    end
  end
endmodule

// File: tb/fp_signclass_unit_tb.sv
`timescale 1ns/1ps
module fp_signclass_unit_tb_top;
  logic        clk = 1'b0;
  logic [63:0] op_a, op_b, result;
  logic [1:0]  op_sel;
  logic        is_double;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  fp_signclass_unit dut_i (.op_a(op_a), .op_b(op_b), .op_sel(op_sel),
                           .is_double(is_double), .result(result));

  function automatic int class_of(input logic [63:0] a, input logic dbl);
    logic [62:0] mag, inf, minn, qb;
    logic s;
    if (dbl) begin
      mag = a[62:0]; s = a[63];
      inf = 63'h7FF0_0000_0000_0000; minn = 63'h0010_0000_0000_0000; qb = 63'h0008_0000_0000_0000;
    end else begin
      mag = {32'h0, a[30:0]}; s = a[31];
      inf = 63'h7F80_0000; minn = 63'h0080_0000; qb = 63'h0040_0000;
    end
    if (mag == 0)     return s ? 3 : 4;
    if (mag < minn)   return s ? 2 : 5;
    if (mag < inf)    return s ? 1 : 6;
    if (mag == inf)   return s ? 0 : 7;
    return ((mag & qb) != 0) ? 9 : 8;
  endfunction

  function automatic logic [63:0] expect_of(input logic [63:0] a, input logic [63:0] b,
                                            input logic [1:0] op, input logic dbl);
    logic sa, sb, ns;
    logic [63:0] r;
    if (op == 2'b11) begin
      r = 64'h0;
      r[class_of(a, dbl)] = 1'b1;
      return r;
    end
    sa = dbl ? a[63] : a[31];
    sb = dbl ? b[63] : b[31];
    ns = (op == 2'b00) ? sb : (op == 2'b01) ? !sb : (sa != sb);
    if (dbl) begin r = a; r[63] = ns; end
    else begin r = {32'hFFFF_FFFF, a[31:0]}; r[31] = ns; end
    return r;
  endfunction

  function automatic string tag_of(input logic [63:0] a, input logic [1:0] op, input logic dbl);
    int c;
    if (op != 2'b11) begin
      if (!dbl) return "R4";
      return (op == 2'b00) ? "R1" : (op == 2'b01) ? "R2" : "R3";
    end
    c = class_of(a, dbl);
    if (c == 8 || c == 9) return "R8";
    if (c == 0 || c == 3 || c == 4 || c == 7) return "R6";
    return "R7";
  endfunction

  task automatic apply(input logic [63:0] a, input logic [63:0] b,
                       input logic [1:0] op, input logic dbl, input string tag);
    logic [63:0] exp_r;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; is_double = dbl;
    #1;
    exp_r = expect_of(a, b, op, dbl);
    n_run++;
    if (result !== exp_r) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h op=%0d dbl=%0d got=%h exp=%h", tag, a, b, op, dbl, result, exp_r);
    end
  endtask

  task automatic go(input logic [63:0] a, input logic [63:0] b, input logic [1:0] op, input logic dbl);
    apply(a, b, op, dbl, tag_of(a, op, dbl));
  endtask

  function automatic logic [63:0] rnd_val(input logic dbl);
    logic [63:0] v;
    int pick;
    v = {$urandom, $urandom};
    pick = $urandom_range(0, 3);
    if (dbl) begin
      if (pick == 0) v[62:52] = '0;
      if (pick == 1) v[62:52] = '1;
      if (pick == 2 && $urandom_range(0, 1) == 1) v[51:0] = '0;
    end else begin
      if (pick == 0) v[30:23] = '0;
      if (pick == 1) v[30:23] = '1;
      if (pick == 2 && $urandom_range(0, 1) == 1) v[22:0] = '0;
    end
    return v;
  endfunction

  initial begin
    logic [63:0] r1;
    void'($urandom(32'd2024));
    op_a = 0; op_b = 0; op_sel = 2'b11; is_double = 1'b1;
    // idle state: classify of +0.0
    apply(64'h0, 64'h0, 2'b11, 1'b1, "R5");
    // R6 double and single
    go(64'hFFF0_0000_0000_0000, 0, 2'b11, 1);
    go(64'h7FF0_0000_0000_0000, 0, 2'b11, 1);
    go(64'h8000_0000_0000_0000, 0, 2'b11, 1);
    go(64'hDEAD_BEEF_FF80_0000, 0, 2'b11, 0);
    go(64'h1234_5678_8000_0000, 0, 2'b11, 0);
    // R7 boundaries
    go(64'h000F_FFFF_FFFF_FFFF, 0, 2'b11, 1);
    go(64'h0010_0000_0000_0000, 0, 2'b11, 1);
    go(64'h8000_0000_0000_0001, 0, 2'b11, 1);
    go(64'hFFEF_FFFF_FFFF_FFFF, 0, 2'b11, 1);
    go(64'h0000_0000_007F_FFFF, 0, 2'b11, 0);
    go(64'hFFFF_FFFF_8080_0000, 0, 2'b11, 0);
    // R8 NaN split, sign ignored
    go(64'h7FF8_0000_0000_0000, 0, 2'b11, 1);
    go(64'hFFF8_0000_0000_0001, 0, 2'b11, 1);
    go(64'h7FF0_0000_0000_0001, 0, 2'b11, 1);
    go(64'hFFF4_0000_0000_0000, 0, 2'b11, 1);
    go(64'h0000_0000_FFC0_0000, 0, 2'b11, 0);
    go(64'h0000_0000_FF80_0001, 0, 2'b11, 0);
    // R1 R2 R3 with NaN payloads kept
    go(64'h7FF4_5555_AAAA_1234, 64'h8000_0000_0000_0000, 2'b00, 1);
    go(64'hFFF4_5555_AAAA_1234, 64'h8000_0000_0000_0000, 2'b01, 1);
    go(64'hFFF4_5555_AAAA_1234, 64'h8000_0000_0000_0000, 2'b10, 1);
    go(64'h3FF0_0000_0000_0000, 64'h0, 2'b10, 1);
    // R4 single with junk upper halves
    go(64'h0123_4567_7FC0_0001, 64'hFFFF_FFFF_8000_0000, 2'b00, 0);
    go(64'hFFFF_FFFF_BF80_0000, 64'h0000_0000_0000_0000, 2'b01, 0);
    go(64'h0000_0000_BF80_0000, 64'h7FFF_FFFF_FFFF_FFFF, 2'b10, 0);
    // R9: B and upper A bits do not change classify
    apply(64'h0000_0000_3F80_0000, 64'hFFFF_FFFF_FFFF_FFFF, 2'b11, 0, "R9");
    r1 = result;
    apply(64'hFFF8_0000_3F80_0000, 64'h0, 2'b11, 0, "R9");
    n_run++;
    if (result !== r1) begin
      n_fail++;
      $display("FAIL R9 got=%h exp=%h", result, r1);
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic dbl;
      logic [1:0] op;
      dbl = 1'($urandom_range(0, 1));
      op  = 2'($urandom_range(0, 3));
      go(rnd_val(dbl), {$urandom, $urandom}, op, dbl);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule